// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading translation entries from memory. Software first loads a root pointer that gives the physical frame of the top-level directory. A request then starts a walk. The walker reads one directory entry, and in most cases one table entry after that, through a single memory read port. It finishes with either a physical address or a page-fault report. Only one walk is in progress at any time. A new request is taken only while the walker is idle.

For a normal 4 KB page the address splits into three fields. The top ten bits index the directory, the next ten bits index the table, and the low twelve bits are the byte offset. When the large-page enable is set and the directory entry asks for it, the table level is skipped. The address then splits into a ten-bit directory index and a 22-bit offset inside a 4 MB frame. The walker has seven states:
- IDLE: waits for a request.
- DIR_REQ: issues the directory read.
- DIR_WAIT: waits for the directory entry.
- TBL_REQ: issues the table read.
- TBL_WAIT: waits for the table entry.
- DONE: presents the result for one cycle.
- FAULT: presents the fault for one cycle.

The transitions are:
- IDLE→DIR_REQ on request.
- DIR_REQ→DIR_WAIT always.
- DIR_WAIT→FAULT on a non-present entry.
- DIR_WAIT→DONE on a present large-page entry.
- DIR_WAIT→TBL_REQ otherwise.
- TBL_REQ→TBL_WAIT always.
- TBL_WAIT→DONE on a present entry.
- TBL_WAIT→FAULT on a non-present entry.
- DONE→IDLE and FAULT→IDLE always.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle. `req_ready` is 1, and `mem_rd_en`, `done_valid` and `fault_valid` are 0.
- R2: One cycle after a request is accepted, the walker raises `mem_rd_en` for exactly one cycle. The read address is root frame × 4096 + directory index × 4, where the directory index is address bits 31:22.
- R3: When the directory entry is present (bit 0 = 1) and does not map a large page, the walker issues one table read. Its address is (entry bits 31:12) × 4096 + table index × 4, where the table index is address bits 21:12.
- R4: When the table entry is present, `done_valid` pulses for one cycle. `done_paddr` then carries table-entry bits 31:12 above address bits 11:0.
- R5: When `large_pg_en` is 1 and the present directory entry has bit 7 set, the walk ends after the single directory read. `done_paddr` is directory-entry bits 31:22 above address bits 21:0.
- R6: When `large_pg_en` is 0, bit 7 of a directory entry is ignored and the full two-level walk is done.
- R7: A directory entry with bit 0 = 0 ends the walk with no table read. `fault_valid` pulses, `fault_addr` is the request address and `fault_level` is 0.
- R8: A table entry with bit 0 = 0 makes `fault_valid` pulse with `fault_addr` equal to the request address and `fault_level` equal to 1.
- R9: `req_ready` is 0 from the cycle after acceptance up to and including the result cycle. Requests offered during that time are ignored. Each walk yields exactly one one-cycle result, either done or fault.
- R10: A root pointer load (`root_ld`, frame taken from `root_base_in` bits 31:12) applies to walks accepted after it. A walk already in progress keeps the root it started with.
- R11: The walker waits any number of cycles for `mem_rd_valid` after each read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_ld | input | 1 | Load the root pointer |
| root_base_in | input | 32 | Directory base address; bits 31:12 are kept |
| large_pg_en | input | 1 | Allows directory entries to map 4 MB pages |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| mem_rd_en | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Physical address of the entry to read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | Translation result valid (one cycle) |
| done_paddr | output | 32 | Physical address result |
| fault_valid | output | 1 | Page fault (one cycle) |
| fault_addr | output | 32 | Linear address that faulted |
| fault_level | output | 1 | 0 = directory entry, 1 = table entry |

## Verification
The hardest situations to reach from the ports all happen while a walk is still in flight: a request offered while the walker is busy, and a root pointer reload. The bench's memory responder holds each read for a programmable number of cycles. This keeps the walker in its wait states long enough to inject a stray request, or to reload the root, before the first entry returns. The expected results come from a behavioural model that captured the root at acceptance. Any second walk or changed address shows up as a mismatch in the read addresses that are compared on every clock.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DIR_REQ  = 3'd1,
        ST_DIR_WAIT = 3'd2,
        ST_TBL_REQ  = 3'd3,
        ST_TBL_WAIT = 3'd4,
        ST_DONE     = 3'd5,
        ST_FAULT    = 3'd6
    } walk_state_e;

    typedef enum logic {
        LVL_DIR = 1'b0,
        LVL_TBL = 1'b1
    } walk_level_e;

endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg #(
    parameter int AW    = 32,
    parameter int OFS_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld,
    input  logic [AW-1:0]       din,
    output logic [AW-OFS_W-1:0] frame
);
    localparam int FRAME_W = AW - OFS_W;

    logic unused_low_bits;
    assign unused_low_bits = ^din[OFS_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame <= '0;
        end else if (ld) begin
            frame <= din[AW-1 -: FRAME_W];
        end
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int AW       = 32,
    parameter int DIR_W    = 10,
    parameter int TBL_W    = 10,
    parameter int OFS_W    = 12,
    parameter int ENT_LOG2 = 2
) (
    input  logic [AW-OFS_W-1:0] dir_frame,
    input  logic [AW-OFS_W-1:0] tbl_frame,
    input  logic [AW-1:0]       lin,
    input  logic [AW-1:0]       ent,
    output logic [AW-1:0]       dir_ent_addr,
    output logic [AW-1:0]       tbl_ent_addr,
    output logic [AW-1:0]       pa_small,
    output logic [AW-1:0]       pa_large
);
    localparam int BIG_OFS_W = TBL_W + OFS_W;

    logic [DIR_W-1:0] dir_idx;
    logic [TBL_W-1:0] tbl_idx;
    logic             unused_ent_low;

    assign dir_idx = lin[AW-1 -: DIR_W];
    assign tbl_idx = lin[OFS_W +: TBL_W];
    assign unused_ent_low = ^ent[OFS_W-1:0];

    always_comb begin
        dir_ent_addr = {dir_frame, {OFS_W{1'b0}}} + (AW'(dir_idx) << ENT_LOG2);
        tbl_ent_addr = {tbl_frame, {OFS_W{1'b0}}} + (AW'(tbl_idx) << ENT_LOG2);
        pa_small     = {ent[AW-1:OFS_W], lin[OFS_W-1:0]};
        pa_large     = {ent[AW-1:BIG_OFS_W], lin[BIG_OFS_W-1:0]};
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
#(
    parameter int AW          = 32,
    parameter int OFS_W       = 12,
    parameter int PRESENT_BIT = 0,
    parameter int LARGE_BIT   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [AW-1:0]       req_addr,
    output logic                req_ready,
    input  logic [AW-OFS_W-1:0] root_frame,
    input  logic                large_en,
    output logic                mem_rd_en,
    output logic [AW-1:0]       mem_rd_addr,
    input  logic                mem_rd_valid,
    input  logic [AW-1:0]       mem_rd_data,
    input  logic [AW-1:0]       dir_ent_addr,
    input  logic [AW-1:0]       tbl_ent_addr,
    input  logic [AW-1:0]       pa_small,
    input  logic [AW-1:0]       pa_large,
    output logic [AW-1:0]       lin_q,
    output logic [AW-OFS_W-1:0] dir_frame_q,
    output logic [AW-OFS_W-1:0] tbl_frame_q,
    output logic                done_valid,
    output logic [AW-1:0]       done_paddr,
    output logic                fault_valid,
    output logic [AW-1:0]       fault_addr,
    output logic                fault_level
);
    walk_state_e state, nxt;
    walk_level_e lvl_q;
    logic [AW-1:0] pa_q;
    logic          pse_q;
    logic          ent_present;
    logic          ent_large;

    assign ent_present = mem_rd_data[PRESENT_BIT];
    assign ent_large   = pse_q && mem_rd_data[LARGE_BIT];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid) nxt = ST_DIR_REQ;
            ST_DIR_REQ:  nxt = ST_DIR_WAIT;
            ST_DIR_WAIT: begin
                if (mem_rd_valid) begin
                    if (!ent_present)   nxt = ST_FAULT;
                    else if (ent_large) nxt = ST_DONE;
                    else                nxt = ST_TBL_REQ;
                end
            end
            ST_TBL_REQ:  nxt = ST_TBL_WAIT;
            ST_TBL_WAIT: begin
                if (mem_rd_valid) nxt = ent_present ? ST_DONE : ST_FAULT;
            end
            ST_DONE:     nxt = ST_IDLE;
            ST_FAULT:    nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lin_q       <= '0;
            dir_frame_q <= '0;
            tbl_frame_q <= '0;
            pse_q       <= 1'b0;
            pa_q        <= '0;
            lvl_q       <= LVL_DIR;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lin_q       <= req_addr;
                        dir_frame_q <= root_frame;
                        pse_q       <= large_en;
                    end
                end
                ST_DIR_WAIT: begin
                    if (mem_rd_valid) begin
                        tbl_frame_q <= mem_rd_data[AW-1:OFS_W];
                        if (!ent_present)   lvl_q <= LVL_DIR;
                        else if (ent_large) pa_q  <= pa_large;
                    end
                end
                ST_TBL_WAIT: begin
                    if (mem_rd_valid) begin
                        if (ent_present) pa_q  <= pa_small;
                        else             lvl_q <= LVL_TBL;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready   = (state == ST_IDLE);
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        unique case (state)
            ST_DIR_REQ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = dir_ent_addr;
            end
            ST_TBL_REQ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = tbl_ent_addr;
            end
            default: ;
        endcase
        done_valid  = (state == ST_DONE);
        done_paddr  = pa_q;
        fault_valid = (state == ST_FAULT);
        fault_addr  = lin_q;
        fault_level = (lvl_q == LVL_TBL);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int AW          = 32,
    parameter int DIR_W       = 10,
    parameter int TBL_W       = 10,
    parameter int OFS_W       = 12,
    parameter int ENT_LOG2    = 2,
    parameter int PRESENT_BIT = 0,
    parameter int LARGE_BIT   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          root_ld,
    input  logic [AW-1:0] root_base_in,
    input  logic          large_pg_en,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [AW-1:0] mem_rd_data,
    output logic          done_valid,
    output logic [AW-1:0] done_paddr,
    output logic          fault_valid,
    output logic [AW-1:0] fault_addr,
    output logic          fault_level
);
    localparam int FRAME_W = AW - OFS_W;

    logic [FRAME_W-1:0] root_frame;
    logic [FRAME_W-1:0] dir_frame_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic [AW-1:0]      lin_q;
    logic [AW-1:0]      dir_ent_addr;
    logic [AW-1:0]      tbl_ent_addr;
    logic [AW-1:0]      pa_small;
    logic [AW-1:0]      pa_large;

    ptw_root_reg #(.AW(AW), .OFS_W(OFS_W)) root_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (root_ld),
        .din   (root_base_in),
        .frame (root_frame)
    );

    ptw_addr_gen #(
        .AW(AW), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFS_W(OFS_W), .ENT_LOG2(ENT_LOG2)
    ) agen_i (
        .dir_frame    (dir_frame_q),
        .tbl_frame    (tbl_frame_q),
        .lin          (lin_q),
        .ent          (mem_rd_data),
        .dir_ent_addr (dir_ent_addr),
        .tbl_ent_addr (tbl_ent_addr),
        .pa_small     (pa_small),
        .pa_large     (pa_large)
    );

    ptw_fsm #(
        .AW(AW), .OFS_W(OFS_W), .PRESENT_BIT(PRESENT_BIT), .LARGE_BIT(LARGE_BIT)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_ready    (req_ready),
        .root_frame   (root_frame),
        .large_en     (large_pg_en),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .dir_ent_addr (dir_ent_addr),
        .tbl_ent_addr (tbl_ent_addr),
        .pa_small     (pa_small),
        .pa_large     (pa_large),
        .lin_q        (lin_q),
        .dir_frame_q  (dir_frame_q),
        .tbl_frame_q  (tbl_frame_q),
        .done_valid   (done_valid),
        .done_paddr   (done_paddr),
        .fault_valid  (fault_valid),
        .fault_addr   (fault_addr),
        .fault_level  (fault_level)
    );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic mem_rd_en,
    input logic done_valid,
    input logic fault_valid
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_en && !done_valid && !fault_valid)); // R1

    AST_ACCEPT_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_en && !req_ready)); // R2

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R2

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid)); // R9

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |=> (!done_valid && !fault_valid && req_ready)); // R9

    AST_BUSY_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |-> !req_ready); // R9
endmodule

bind pt_walker ptw_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .mem_rd_en   (mem_rd_en),
    .done_valid  (done_valid),
    .fault_valid (fault_valid)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_ld = 1'b0;
    logic [31:0] root_base_in = '0;
    logic        large_pg_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic        fault_valid;
    logic [31:0] fault_addr;
    logic        fault_level;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .root_ld(root_ld), .root_base_in(root_base_in),
        .large_pg_en(large_pg_en), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done_valid(done_valid), .done_paddr(done_paddr),
        .fault_valid(fault_valid), .fault_addr(fault_addr), .fault_level(fault_level)
    );

    initial forever #4 clk = ~clk;   // 125 MHz

    int nchecks = 0;
    int nerrs   = 0;
    bit finished = 0;
    bit started  = 0;

    // behavioural memory and reference state
    logic [31:0] mem [logic [31:0]];
    logic [31:0] root_shadow = '0;
    bit          pse_shadow = 0;
    int          lat = 0;
    int          phase = 0;          // 0 idle, 1 offered, 2 walking
    logic [31:0] exp_rd [2];
    int          exp_n = 0;
    int          rd_seen = 0;
    bit          exp_fault = 0;
    bit          exp_lvl = 0;
    logic [31:0] exp_pa = '0;
    logic [31:0] exp_va = '0;
    string       exp_tag = "";

    function automatic logic [31:0] peek(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        nchecks++;
        if (!ok) begin
            nerrs++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // reference walk computed from the requirements
    task automatic predict(logic [31:0] va);
        logic [31:0] pde, pte, a;
        exp_va = va;
        a = {root_shadow[31:12], 12'h0} + {20'h0, va[31:22], 2'b00};
        exp_rd[0] = a; exp_n = 1;
        pde = peek(a);
        if (!pde[0]) begin
            exp_fault = 1; exp_lvl = 0;
        end else if (pse_shadow && pde[7]) begin
            exp_fault = 0; exp_pa = {pde[31:22], va[21:0]};
        end else begin
            a = {pde[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
            exp_rd[1] = a; exp_n = 2;
            pte = peek(a);
            if (!pte[0]) begin
                exp_fault = 1; exp_lvl = 1;
            end else begin
                exp_fault = 0; exp_pa = {pte[31:12], va[11:0]};
            end
        end
    endtask

    task automatic wait_idle();
        do begin @(posedge clk); #1; end while (phase != 0);
    endtask

    task automatic walk(logic [31:0] va, string tag);
        wait_idle();
        predict(va);
        exp_tag = tag; rd_seen = 0;
        req_addr = va; req_valid = 1'b1; phase = 1;
        @(posedge clk); #1;
        req_valid = 1'b0; phase = 2;
    endtask

    task automatic load_root(logic [31:0] v);
        @(posedge clk); #1;
        root_ld = 1'b1; root_base_in = v;
        @(posedge clk); #1;
        root_ld = 1'b0; root_shadow = v;
    endtask

    // memory responder with programmable latency
    initial begin
        bit          pend = 0;
        int          cnt = 0;
        logic [31:0] pa = '0;
        forever begin
            @(negedge clk);
            if (mem_rd_valid) mem_rd_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rd_valid = 1'b1; mem_rd_data = peek(pa); pend = 0;
                end else cnt--;
            end
            if (rst_n && mem_rd_en) begin
                pend = 1; cnt = lat; pa = mem_rd_addr;
            end
        end
    end

    // per-clock comparison against the reference
    initial begin
        forever begin
            @(negedge clk);
            if (started && !finished) begin
                chk(req_ready === (phase != 2), "R9", "ready", {31'b0, req_ready}, {31'b0, phase != 2});
                if (mem_rd_en) begin
                    if (phase != 2 || rd_seen >= exp_n) begin
                        chk(0, "R9", "unexpected read", mem_rd_addr, 32'h0);
                    end else begin
                        chk(mem_rd_addr === exp_rd[rd_seen], (rd_seen == 0) ? "R2" : "R3",
                            "entry address", mem_rd_addr, exp_rd[rd_seen]);
                        rd_seen++;
                    end
                end
                if (done_valid || fault_valid) begin
                    chk(phase == 2, "R9", "result while idle", 32'h0, 32'h0);
                    chk(fault_valid === exp_fault && done_valid === !exp_fault, exp_tag,
                        "result kind", {31'b0, fault_valid}, {31'b0, exp_fault});
                    chk(rd_seen == exp_n, exp_tag, "read count", rd_seen, exp_n);
                    if (done_valid)
                        chk(done_paddr === exp_pa, exp_tag, "paddr", done_paddr, exp_pa);
                    if (fault_valid) begin
                        chk(fault_addr === exp_va, exp_tag, "fault addr", fault_addr, exp_va);
                        chk(fault_level === exp_lvl, exp_tag, "fault level",
                            {31'b0, fault_level}, {31'b0, exp_lvl});
                    end
                    phase = 0;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchecks++; nerrs++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
            $finish;
        end
    end

    initial begin
        // memory image
        mem[32'h0001_0004] = 32'h0002_0001;   // dir idx 1 -> table 0x20000
        mem[32'h0002_000C] = 32'h0ABC_D001;   // tbl idx 3 -> frame 0x0ABCD
        mem[32'h0002_0014] = 32'h0033_3000;   // tbl idx 5 not present
        mem[32'h0001_0008] = 32'h12C0_0081;   // dir idx 2 large page
        mem[32'h12C0_0004] = 32'h0077_7003;   // used when large pages are off
        mem[32'h0001_0FFC] = 32'h0002_1001;   // dir idx 0x3FF
        mem[32'h0002_1FFC] = 32'hFFFF_F001;   // tbl idx 0x3FF
        mem[32'h0005_0004] = 32'h0006_0001;   // second root
        mem[32'h0006_000C] = 32'h00BE_E001;

        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1, "R1", "reset ready", {31'b0, req_ready}, 32'h1);
        chk(mem_rd_en === 1'b0, "R1", "reset read", {31'b0, mem_rd_en}, 32'h0);
        chk(done_valid === 1'b0, "R1", "reset done", {31'b0, done_valid}, 32'h0);
        chk(fault_valid === 1'b0, "R1", "reset fault", {31'b0, fault_valid}, 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        started = 1;

        load_root(32'h0001_0ABC);             // low bits dropped
        root_shadow = 32'h0001_0000;

        lat = 0;
        walk(32'h0040_3123, "R4");
        walk(32'hFFFF_FFFF, "R4");
        lat = 3;
        walk(32'h0040_3123, "R11");
        lat = 7;
        walk(32'h0040_5FFF, "R8");
        lat = 1;
        walk(32'h00C0_0000, "R7");
        walk(32'h0080_1ABC, "R6");            // bit 7 ignored while disabled

        wait_idle();
        large_pg_en = 1'b1; pse_shadow = 1;
        walk(32'h0080_1ABC, "R5");
        walk(32'h0040_3123, "R4");

        // request offered while busy must be ignored
        lat = 4;
        walk(32'h0040_3123, "R9");
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = 32'h00C0_0000;
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_idle();
        repeat (3) @(posedge clk);

        // root reload during a walk applies only to later walks
        lat = 5;
        walk(32'h0040_3123, "R10");
        load_root(32'h0005_0000);
        walk(32'h0040_3123, "R10");
        wait_idle();
        repeat (3) @(posedge clk);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
            $finish;
        end
    end
endmodule